// File: doc/BRIEF.md
# Noise-Shaped Fractional Clock Divider

The block divides a fast source clock by a programmable ratio. The ratio has a 12-bit integer part and a 12-bit fraction, and the fraction is worth `div_frac`/4096 of a source cycle. Each output period is a whole number of source cycles. The block obtains the fractional ratio by making some periods one or more source cycles longer or shorter than the integer part. A chain of up to three 12-bit accumulators decides when. Their overflow carries are combined into a noise-shaped correction of order 0, 1, 2 or 3. Higher orders spread the period further around the target, and in exchange they push the period error towards high frequencies.

A new period length is computed once per output period, at the cycle in which the previous period ends. So changes to the ratio or the order only take effect at a period boundary. An enable starts the output, and dropping it lets the running period finish before the output goes quiet. The block reports the length of the current period, in source cycles, on an observation port.

Top module: `frac_clk_div`

## Requirements
- R1: With order 0 (`mash_ord`=0), every output period lasts exactly `div_int` source cycles and the fraction is ignored.
- R2: With order 1, a 12-bit accumulator adds `div_frac` once per period, starting from zero. A period lasts `div_int`+1 cycles when that addition overflows, and `div_int` cycles otherwise.
- R3: With order 2, every period lies between `div_int`-1 and `div_int`+2 source cycles. The correction is c1 + c2 - c2', where c2 is the carry of a second accumulator that sums the first stage's remainder, and the prime marks the value from the previous period.
- R4: With order 3, every period lies between `div_int`-3 and `div_int`+4 source cycles. The correction adds c3 - 2·c3' + c3'' from a third stage.
- R5: Over 1024 consecutive periods with a `div_frac` that is a multiple of 4, the total length is 1024·`div_int` + `div_frac`/4 source cycles. This is exact for orders 0 and 1, where order 0 adds no fraction, and within 3 cycles for orders 2 and 3.
- R6: When `div_int` is below the minimum for the order, the minimum is used instead. The minimum is 1 for order 0, 2 for order 1, 3 for order 2 and 5 for order 3.
- R7: `clk_out` is high during the first ceil(P/2) source cycles of a period of P cycles and low for the rest.
- R8: While idle, `clk_out` is 0 and `period` is 0. A high `en` sampled at an edge starts a period at that edge, with all accumulators and carry history at zero.
- R9: When `en` is low at the last cycle of a period, the block goes idle at the next edge and clears its accumulators. A period is never cut short.
- R10: `div_int`, `div_frac` and `mash_ord` are sampled only at the edge that starts a period. `period` shows the length of the running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request |
| div_int | input | 12 | Integer part of the ratio |
| div_frac | input | 12 | Fraction of the ratio, in 1/4096 units |
| mash_ord | input | 2 | Noise-shaping order 0..3 |
| clk_out | output | 1 | Divided clock |
| period | output | 13 | Length of the running period in source cycles, 0 when idle |

## Verification
The bench targets integer parts below each order's minimum, including zero. A design without the clamp would produce periods of zero or wrapped length and lose lock to the model at once. Long runs with the ratio fixed check the span of period lengths for orders 2 and 3, and the total cycle count over 1024 periods. A wrong carry history or a sign error in the correction widens the span or moves the average. The bench also drops `en` and changes the ratio in the middle of a period. A design that cuts the period short, or takes the new ratio early, then disagrees with the cycle-by-cycle model at that edge.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int IW = 12,
  parameter int FW = 12
) (
  input  logic          clk_src,
  input  logic          rst_n,
  input  logic          en,
  input  logic [IW-1:0] div_int,
  input  logic [FW-1:0] div_frac,
  input  logic [1:0]    mash_ord,
  output logic          clk_out,
  output logic [IW:0]   period
);
  localparam int PW = IW + 1;

  logic          run;
  logic [PW-1:0] cnt, per;
  logic [FW-1:0] acc1, acc2, acc3;
  logic          c2_p, c3_p, c3_pp;

  logic          last, load, stop;
  logic [FW:0]   s1, s2, s3;
  logic [3:0]    d1, d2, d3, delta;
  logic [IW-1:0] min_int, int_eff;
  logic [PW-1:0] nxt_per, hi_len;

  assign last = run && (cnt == per - 1'b1);
  assign load = en && (!run || last);
  assign stop = last && !en;

  assign s1 = {1'b0, acc1} + {1'b0, div_frac};
  assign s2 = {1'b0, acc2} + {1'b0, s1[FW-1:0]};
  assign s3 = {1'b0, acc3} + {1'b0, s2[FW-1:0]};

  assign d1 = {3'b000, s1[FW]};
  assign d2 = {3'b000, s2[FW]} - {3'b000, c2_p};
  assign d3 = {3'b000, s3[FW]} - {2'b00, c3_p, 1'b0} + {3'b000, c3_pp};

  always_comb begin
    case (mash_ord)
      2'd0: begin delta = 4'd0;            min_int = IW'(1); end
      2'd1: begin delta = d1;              min_int = IW'(2); end
      2'd2: begin delta = d1 + d2;         min_int = IW'(3); end
      default: begin delta = d1 + d2 + d3; min_int = IW'(5); end
    endcase
  end

  assign int_eff = (div_int < min_int) ? min_int : div_int;
  assign nxt_per = {1'b0, int_eff} + {{(PW-4){delta[3]}}, delta};
  assign hi_len  = (per + 1'b1) >> 1;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      per   <= '0;
      acc1  <= '0;
      acc2  <= '0;
      acc3  <= '0;
      c2_p  <= 1'b0;
      c3_p  <= 1'b0;
      c3_pp <= 1'b0;
    end else if (load) begin
      run   <= 1'b1;
      cnt   <= '0;
      per   <= nxt_per;
      acc1  <= s1[FW-1:0];
      acc2  <= s2[FW-1:0];
      acc3  <= s3[FW-1:0];
      c2_p  <= s2[FW];
      c3_p  <= s3[FW];
      c3_pp <= c3_p;
    end else if (stop || !run) begin
      run   <= 1'b0;
      cnt   <= '0;
      per   <= '0;
      acc1  <= '0;
      acc2  <= '0;
      acc3  <= '0;
      c2_p  <= 1'b0;
      c3_p  <= 1'b0;
      c3_pp <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign clk_out = run && (cnt < hi_len);
  assign period  = run ? per : '0;

  // R1
  ord0_exact_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (load && mash_ord == 2'd0) |=> (period == {1'b0, $past(int_eff)}));

  // R4
  ord3_span_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (load && mash_ord == 2'd3) |=>
      (period <= {1'b0, $past(int_eff)} + PW'(4) && period + PW'(3) >= {1'b0, $past(int_eff)}));

  // R6
  period_nonzero_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    run |-> (period != '0 && cnt < period));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    !run |-> (!clk_out && period == '0));

  // R9
  stop_at_end_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(run) |-> ($past(cnt) + 1'b1 == $past(per)));

  // R7
  starts_high_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    load |=> clk_out);
endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [11:0] div_int = 12'd0;
  logic [11:0] div_frac = 12'd0;
  logic [1:0]  mash_ord = 2'd0;
  logic        clk_out;
  logic [12:0] period;

  int    n_chk = 0, n_bad = 0, shown = 0;
  string tag = "R8";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  frac_clk_div u_frac_clk_div (
    .clk_src(clk), .rst_n(rst_n), .en(en), .div_int(div_int),
    .div_frac(div_frac), .mash_ord(mash_ord), .clk_out(clk_out), .period(period)
  );

  // behavioural model
  int m_run, m_cnt, m_per, a1, a2, a3, h2, h3, h33;

  function automatic int floor_of(int o);
    case (o)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  task automatic m_clear();
    m_run = 0; m_cnt = 0; m_per = 0;
    a1 = 0; a2 = 0; a3 = 0; h2 = 0; h3 = 0; h33 = 0;
  endtask

  task automatic m_step();
    int c1, c2, c3, d, base;
    a1 = a1 + int'(div_frac); c1 = a1 / 4096; a1 = a1 % 4096;
    a2 = a2 + a1;             c2 = a2 / 4096; a2 = a2 % 4096;
    a3 = a3 + a2;             c3 = a3 / 4096; a3 = a3 % 4096;
    case (int'(mash_ord))
      0: d = 0;
      1: d = c1;
      2: d = c1 + c2 - h2;
      default: d = c1 + c2 - h2 + c3 - 2 * h3 + h33;
    endcase
    base = (int'(div_int) < floor_of(int'(mash_ord))) ? floor_of(int'(mash_ord)) : int'(div_int);
    m_per = base + d;
    h2 = c2; h33 = h3; h3 = c3;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_clear();
    else begin
      bit at_end;
      at_end = (m_run != 0) && (m_cnt == m_per - 1);
      if (en && (m_run == 0 || at_end)) begin
        m_step(); m_run = 1; m_cnt = 0;
      end else if (m_run == 0 || at_end) m_clear();
      else m_cnt = m_cnt + 1;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      if (shown < 20) $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      shown++;
    end
  endtask

  // cycle-by-cycle comparison (R7, R10 and the active phase tag)
  always @(negedge clk) if (rst_n && !done) begin
    int e_clk, e_per;
    e_clk = (m_run != 0 && m_cnt < (m_per + 1) / 2) ? 1 : 0;
    e_per = (m_run != 0) ? m_per : 0;
    check(int'(clk_out) == e_clk, {tag, "/R7"}, "clk_out", int'(clk_out), e_clk);
    check(int'(period) == e_per, {tag, "/R10"}, "period", int'(period), e_per);
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(int di, int df, int od);
    div_int = 12'(di); div_frac = 12'(df); mash_ord = 2'(od);
  endtask

  task automatic span(int n, output int lo, output int hi);
    lo = 1 << 20; hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (period != 0) begin
        if (int'(period) < lo) lo = int'(period);
        if (int'(period) > hi) hi = int'(period);
      end
    end
  endtask

  task automatic stop_and_idle();
    @(negedge clk); en = 1'b0;
    repeat (5000) begin
      @(negedge clk);
      if (period == 0) break;
    end
    cycles(2);
  endtask

  task automatic avg_run(int od, int di, int df, int exp, int tol);
    int total, edges;
    bit prev;
    tag = "R5";
    setup(di, df, od);
    @(negedge clk); en = 1'b1;
    prev = 1'b1;
    while (!(clk_out && !prev)) begin prev = clk_out; @(negedge clk); end
    total = 0; edges = 0; prev = 1'b1;
    while (edges < 1024) begin
      @(negedge clk);
      total++;
      if (clk_out && !prev) edges++;
      prev = clk_out;
    end
    check((total - exp <= tol) && (exp - total <= tol), "R5", "cycles in 1024 periods", total, exp);
    stop_and_idle();
  endtask

  initial begin
    int lo, hi;
    cycles(3);
    check(clk_out == 1'b0, "R8", "clk_out in reset", int'(clk_out), 0);
    check(period == 13'd0, "R8", "period in reset", int'(period), 0);
    rst_n = 1'b1;
    cycles(3);
    check(period == 13'd0, "R8", "period idle", int'(period), 0);

    tag = "R1";
    setup(7, 12'h9AB, 0); en = 1'b1;
    span(60, lo, hi);
    check(lo == 7 && hi == 7, "R1", "order 0 span", hi - lo, 0);

    tag = "R9";
    cycles(3); div_int = 12'd4;
    span(20, lo, hi);
    check(lo == 4, "R9", "new ratio after boundary", lo, 4);
    stop_and_idle();
    check(period == 13'd0 && clk_out == 1'b0, "R9", "idle after stop", int'(period), 0);

    tag = "R6";
    setup(0, 0, 0); en = 1'b1;
    span(10, lo, hi);
    check(lo == 1 && hi == 1, "R6", "order 0 floor", lo, 1);
    stop_and_idle();

    tag = "R2";
    setup(1, 12'h800, 1); en = 1'b1;
    span(60, lo, hi);
    check(lo == 2 && hi == 3, "R2", "order 1 floor/span", hi * 10 + lo, 32);
    stop_and_idle();

    tag = "R3";
    setup(0, 12'h555, 2); en = 1'b1;
    span(3000, lo, hi);
    check(lo >= 2 && hi <= 5, "R3", "order 2 span (floor 3)", hi * 10 + lo, 52);
    stop_and_idle();

    tag = "R4";
    setup(2, 12'h3C7, 3); en = 1'b1;
    span(6000, lo, hi);
    check(lo >= 2 && hi <= 9, "R4", "order 3 span (floor 5)", hi * 10 + lo, 92);
    check(hi - lo >= 3, "R4", "order 3 spreads", hi - lo, 3);
    stop_and_idle();

    tag = "R10";
    setup(9, 12'h123, 3); en = 1'b1;
    cycles(4);
    setup(20, 12'hF00, 1);
    cycles(80);
    en = 1'b0; cycles(3); en = 1'b1;
    cycles(60);
    stop_and_idle();

    avg_run(0, 6, 12'h2A4, 6144, 0);
    avg_run(1, 6, 12'h2A4, 6313, 0);
    avg_run(2, 6, 12'h2A4, 6313, 3);
    avg_run(3, 6, 12'h2A4, 6313, 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    done = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule